// File: doc/BRIEF.md
# Self-Test Refresh Scheduler

This block keeps DRAM contents alive while an on-chip memory self-test engine has taken over the command bus and the host has stopped issuing refresh. It runs as its own state machine, separate from the test sequencer. It wakes only while the self-test is active and stays silent otherwise. A programmable interval timer, counted in command clocks, marks each point at which a refresh becomes due. Due refreshes are queued in a small counter.

Each queued refresh is offered to the test sequencer through a request/grant handshake, so that it lands between test commands. When the sequencer grants, the block emits a single-cycle refresh command. It then holds a busy flag for a programmable recovery time, and during that time the sequencer must not issue commands. The interval lives in a 15-bit register inside the block. The register loads on a write strobe and comes out of reset at 3120 clocks, which is 7.8 µs with a 400 MHz command clock.

Top module: `rfsh_sched`

## Requirements
- R1: Out of reset, and in every cycle after a clock edge that saw `testActive` low, `refReq`, `refCmd` and `refBusy` are 0, `pendCount` is 0 and `pendOvf` is 0.
- R2: The interval register resets to 3120. With no write, the first `refReq` appears 3120 clocks after the edge that first samples `testActive` high.
- R3: A write (`ivlWrEn` high for one cycle) stores `ivlWrData`. The stored value N sets the period of the next run to N clocks. A stored 0 behaves as 1.
- R4: While the test is active, the interval timer reloads itself on every expiry. Each expiry adds one to `pendCount`, whether or not earlier refreshes have been granted.
- R5: `refReq` is high exactly when the scheduler is in its run state with `pendCount` non-zero. A clock edge that samples `refReq` and `refGrant` both high gives a one-cycle `refCmd` in the next cycle and lowers `pendCount` by one. `refGrant` without `refReq` has no effect.
- R6: `refBusy` goes high in the same cycle as `refCmd` and stays high for `holdCfg`+1 cycles. `refReq` is low while `refBusy` is high.
- R7: `pendCount` saturates at 8. An expiry that arrives while it is already 8 sets `pendOvf`, which stays set until the test ends.
- R8: Lowering `testActive` drops any pending request and returns the block to idle at the next clock edge, whatever state it was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rstN | input | 1 | Active-low synchronous reset |
| testActive | input | 1 | Self-test engine owns the DRAM command bus |
| ivlWrEn | input | 1 | Write strobe for the interval register |
| ivlWrData | input | 15 | Interval in command clocks |
| holdCfg | input | 8 | Recovery hold-off after a refresh, in clocks (busy lasts holdCfg+1) |
| refGrant | input | 1 | Sequencer grants the bus at a command boundary |
| refReq | output | 1 | A refresh is pending and is offered to the sequencer |
| refCmd | output | 1 | One-cycle refresh command pulse |
| refBusy | output | 1 | Recovery hold-off; the sequencer must withhold commands |
| pendCount | output | 4 | Number of refreshes due but not yet issued |
| pendOvf | output | 1 | Sticky flag: a refresh fell due while eight were already queued |

## Verification
The embedded properties assume `refGrant` is only meaningful while `refReq` is high. They also assume `holdCfg` and `ivlWrData` are held steady while a refresh is in flight, since a change mid-hold would shift the busy window. The directed stimulus changes these inputs only on the falling clock edge. It reprograms the interval only while the scheduler is idle, and it raises the grant only after it has seen the request. The abort check drops `testActive` while requests are still pending, and it does so outside the grant handshake.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } rfshState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic startLd;   // load timer at test start
    logic clearAll;  // test ended: wipe counters
    logic countEn;   // timer decrements
    logic takeOne;   // a refresh was granted
    logic holdTick;  // recovery counter decrements
  } rfshStrobe_t;

endpackage

// File: rtl/rfsh_dpath.sv
module rfsh_dpath
  import rfsh_pkg::*;
#(
  parameter int IVL_W    = 15,
  parameter int DEF_IVL  = 3120,
  parameter int HOLD_W   = 8,
  parameter int PEND_MAX = 8,
  localparam int PEND_W  = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ivlWrEn,
  input  logic [IVL_W-1:0]  ivlWrData,
  input  logic [HOLD_W-1:0] holdCfg,
  input  rfshStrobe_t       stb,
  output logic              holdDone,
  output logic [PEND_W-1:0] pendCount,
  output logic              pendOvf
);

  localparam logic [IVL_W-1:0]  IVL_ONE  = IVL_W'(1);
  localparam logic [PEND_W-1:0] PEND_TOP = PEND_W'(PEND_MAX);

  logic [IVL_W-1:0]  ivlReg;
  logic [IVL_W-1:0]  effIvl;
  logic [IVL_W-1:0]  intCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              expire;

  assign effIvl   = (ivlReg == '0) ? IVL_ONE : ivlReg;
  assign expire   = stb.countEn && (intCnt <= IVL_ONE);
  assign holdDone = (holdCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN)        ivlReg <= IVL_W'(DEF_IVL);
    else if (ivlWrEn) ivlReg <= ivlWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearAll) intCnt <= '0;
    else if (stb.startLd)      intCnt <= effIvl;
    else if (expire)           intCnt <= effIvl;
    else if (stb.countEn)      intCnt <= intCnt - IVL_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearAll) begin
      pendCount <= '0;
      pendOvf   <= 1'b0;
    end else begin
      unique case ({expire, stb.takeOne})
        2'b10: begin
          if (pendCount == PEND_TOP) pendOvf <= 1'b1;
          else                       pendCount <= pendCount + 1'b1;
        end
        2'b01:   pendCount <= pendCount - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         holdCnt <= '0;
    else if (stb.takeOne)              holdCnt <= holdCfg;
    else if (stb.holdTick && !holdDone) holdCnt <= holdCnt - 1'b1;
  end

  a_r7_pend_bound: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= PEND_TOP);

  a_r7_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendOvf) |-> $past(pendCount) == PEND_TOP);

  a_r5_take_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeOne |-> pendCount != '0);

endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        testActive,
  input  logic        refGrant,
  input  logic        pendNz,
  input  logic        holdDone,
  output rfshStrobe_t stb,
  output logic        refReq,
  output logic        refCmd,
  output logic        refBusy
);

  rfshState_e state, stateNxt;
  logic       take;

  assign refReq  = (state == ST_RUN) && pendNz;
  assign refBusy = (state == ST_HOLD);
  assign take    = refReq && refGrant && testActive;

  always_comb begin
    stb.startLd  = (state == ST_IDLE) && testActive;
    stb.clearAll = !testActive;
    stb.countEn  = testActive && (state != ST_IDLE);
    stb.takeOne  = take;
    stb.holdTick = testActive && (state == ST_HOLD);
  end

  always_comb begin
    stateNxt = state;
    if (!testActive) stateNxt = ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE: stateNxt = ST_RUN;
        ST_RUN:  if (take)     stateNxt = ST_HOLD;
        ST_HOLD: if (holdDone) stateNxt = ST_RUN;
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      refCmd <= 1'b0;
    end else begin
      state  <= stateNxt;
      refCmd <= take;
    end
  end

  a_r5_cmd_single: assert property (@(posedge clk) disable iff (!rstN)
    refCmd |=> !refCmd);

  a_r5_cmd_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    refCmd |-> $past(refReq && refGrant));

  a_r6_busy_with_cmd: assert property (@(posedge clk) disable iff (!rstN)
    refCmd |-> refBusy);

  a_r6_no_req_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    refBusy |-> !refReq);

  a_r8_abort_next_clock: assert property (@(posedge clk) disable iff (!rstN)
    !testActive |=> (!refReq && !refBusy && !refCmd));

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int IVL_W    = 15,
  parameter int DEF_IVL  = 3120,
  parameter int HOLD_W   = 8,
  parameter int PEND_MAX = 8,
  localparam int PEND_W  = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testActive,
  input  logic              ivlWrEn,
  input  logic [IVL_W-1:0]  ivlWrData,
  input  logic [HOLD_W-1:0] holdCfg,
  input  logic              refGrant,
  output logic              refReq,
  output logic              refCmd,
  output logic              refBusy,
  output logic [PEND_W-1:0] pendCount,
  output logic              pendOvf
);

  rfshStrobe_t stb;
  logic        holdDone;

  rfsh_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .testActive (testActive),
    .refGrant   (refGrant),
    .pendNz     (pendCount != '0),
    .holdDone   (holdDone),
    .stb        (stb),
    .refReq     (refReq),
    .refCmd     (refCmd),
    .refBusy    (refBusy)
  );

  rfsh_dpath #(
    .IVL_W    (IVL_W),
    .DEF_IVL  (DEF_IVL),
    .HOLD_W   (HOLD_W),
    .PEND_MAX (PEND_MAX)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ivlWrEn   (ivlWrEn),
    .ivlWrData (ivlWrData),
    .holdCfg   (holdCfg),
    .stb       (stb),
    .holdDone  (holdDone),
    .pendCount (pendCount),
    .pendOvf   (pendOvf)
  );

endmodule

// File: tb/rfsh_sched_tb.sv
module rfsh_sched_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        testActive = 1'b0;
  logic        ivlWrEn = 1'b0;
  logic [14:0] ivlWrData = '0;
  logic [7:0]  holdCfg = '0;
  logic        refGrant = 1'b0;
  logic        refReq, refCmd, refBusy, pendOvf;
  logic [3:0]  pendCount;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  rfsh_sched u_dut (
    .clk(clk), .rstN(rstN), .testActive(testActive), .ivlWrEn(ivlWrEn),
    .ivlWrData(ivlWrData), .holdCfg(holdCfg), .refGrant(refGrant),
    .refReq(refReq), .refCmd(refCmd), .refBusy(refBusy),
    .pendCount(pendCount), .pendOvf(pendOvf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idleChk(input string tag);
    chk({tag, " refReq"}, refReq, 0);
    chk({tag, " refCmd"}, refCmd, 0);
    chk({tag, " refBusy"}, refBusy, 0);
    chk({tag, " pendCount"}, pendCount, 0);
    chk({tag, " pendOvf"}, pendOvf, 0);
  endtask

  task automatic writeIvl(input int v);
    @(negedge clk);
    ivlWrData = 15'(v);
    ivlWrEn = 1'b1;
    @(negedge clk);
    ivlWrEn = 1'b0;
  endtask

  // raise testActive, count falling edges until refReq is seen
  task automatic startAndMeasure(output int cnt);
    cnt = 0;
    testActive = 1'b1;
    do begin
      @(negedge clk);
      cnt++;
    end while (!refReq && cnt < 40000);
  endtask

  task automatic stopTest();
    testActive = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    idleChk("R1 reset");
  endtask

  task automatic testDefault();
    int n;
    startAndMeasure(n);
    chk("R2 default interval", n, 3120 + 1);
    stopTest();
  endtask

  task automatic testProgrammed();
    int n;
    writeIvl(5);
    startAndMeasure(n);
    chk("R3 programmed interval 5", n, 6);
    chk("R4 first pending", pendCount, 1);
    repeat (5) @(negedge clk);
    chk("R4 second expiry queued", pendCount, 2);
    repeat (5) @(negedge clk);
    chk("R4 third expiry queued", pendCount, 3);
    stopTest();
  endtask

  task automatic testZero();
    int n;
    writeIvl(0);
    startAndMeasure(n);
    chk("R3 zero acts as one", n, 2);
    @(negedge clk);
    chk("R3 zero period one", pendCount, 2);
    stopTest();
  endtask

  task automatic testGrant();
    int n;
    int busyCnt;
    writeIvl(40);
    holdCfg = 8'd3;
    refGrant = 1'b1;  // grant with nothing pending is ignored
    repeat (10) @(negedge clk);
    chk("R5 grant without req cmd", refCmd, 0);
    chk("R5 grant without req busy", refBusy, 0);
    refGrant = 1'b0;
    stopTest();
    startAndMeasure(n);
    chk("R5 req after interval", n, 41);
    refGrant = 1'b1;
    @(negedge clk);
    refGrant = 1'b0;
    chk("R5 cmd pulse", refCmd, 1);
    chk("R6 busy with cmd", refBusy, 1);
    chk("R6 req low while busy", refReq, 0);
    chk("R5 pending decremented", pendCount, 0);
    busyCnt = 1;
    @(negedge clk);
    chk("R5 cmd single cycle", refCmd, 0);
    while (refBusy && busyCnt < 100) begin
      busyCnt++;
      @(negedge clk);
    end
    chk("R6 busy length hold+1", busyCnt, 4);
    stopTest();
  endtask

  task automatic testOverflow();
    writeIvl(1);
    testActive = 1'b1;
    repeat (9) @(negedge clk);
    chk("R7 pending at eight", pendCount, 8);
    chk("R7 no overflow at eight", pendOvf, 0);
    repeat (5) @(negedge clk);
    chk("R7 saturated", pendCount, 8);
    chk("R7 overflow set", pendOvf, 1);
    chk("R7 req still up", refReq, 1);
    stopTest();
    idleChk("R8 abort clears");
  endtask

  task automatic testInactive();
    int seen = 0;
    writeIvl(1);
    repeat (50) begin
      @(negedge clk);
      if (refReq || refCmd || refBusy || pendCount != 0) seen++;
    end
    chk("R1 quiet while inactive", seen, 0);
  endtask

  task automatic testAbortInHold();
    int n;
    writeIvl(10);
    holdCfg = 8'd20;
    startAndMeasure(n);
    refGrant = 1'b1;
    @(negedge clk);
    refGrant = 1'b0;
    chk("R6 in hold before abort", refBusy, 1);
    stopTest();
    idleChk("R8 abort from hold");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDefault();
    testProgrammed();
    testZero();
    testGrant();
    testOverflow();
    testInactive();
    testAbortInHold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule